// File: doc/BRIEF.md
# Three-TUG-3 VC-4 Payload Interleaver

This block assembles a 9-row by 261-column VC-4 from three 9-row by 86-column TUG-3 byte streams and one path overhead byte stream. Each row starts with one path overhead byte. Two fixed stuff columns follow it. The remaining 258 columns take one byte from each TUG-3 in turn, so the three groups are byte-interleaved column by column. Together, the stuff columns and the interleaved columns make up the 260-column container. Each TUG-3 already carries its own VC-3, TU pointer and fill bytes, and this block passes them through untouched.

Every source has a valid/ready handshake. Only the source whose byte is due next is offered ready, and a missing byte stalls the whole row. The block never reorders or skips a byte. The output is a byte with a valid strobe, its row and column, and a frame-start strobe on the first overhead byte of each frame. The output appears one cycle after the byte is accepted. The overhead byte values come from outside the block. Pointer processing and tributary mapping happen elsewhere.

Top module: `vc4_tug3_interleaver`

## Requirements
- R1: While reset is held and on the first cycle after it, `out_valid` and `out_sof` are 0. The scan position starts at row 0, column 0, so `poh_ready` is 1 and every `tug_ready` bit is 0.
- R2: Output column 0 of every row carries the next byte taken from `poh_data`. `poh_ready` is 1 only while the scan sits on column 0.
- R3: Output columns 1 and 2 of every row carry 0x00 and consume no input. During them all ready outputs are 0.
- R4: Output column c, for c from 3 to 260, carries the next byte of TUG-3 lane (c-3) mod 3. Lane 0 is the low byte of `tug_data` (bits 7:0), lane 1 is bits 15:8 and lane 2 is bits 23:16. Bytes of each lane leave in the order they arrived.
- R5: At most one ready output is 1 in any cycle. `tug_ready[k]` is 1 exactly when the scan sits on a column owned by lane k.
- R6: If the source due at the current column has its valid low, no byte is taken. The next cycle has `out_valid` at 0 and the scan position unchanged.
- R7: Columns advance from 0 to 260 by one per emitted byte. After column 260 the scan returns to column 0 of the next row, and after row 8 it returns to row 0.
- R8: `out_sof` is 1 only together with `out_valid`, and only on row 0, column 0.
- R9: A byte accepted in a cycle (a handshake, or a stuff column) appears at the output with `out_valid` set on the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| poh_data | input | 8 | Path overhead byte for column 0 |
| poh_valid | input | 1 | Overhead byte present |
| poh_ready | output | 1 | Overhead byte is taken when valid |
| tug_data | input | 24 | Three TUG-3 bytes, lane k at bits 8k+7:8k |
| tug_valid | input | 3 | Per-lane byte present |
| tug_ready | output | 3 | Per-lane byte is taken when valid |
| out_data | output | 8 | VC-4 byte |
| out_valid | output | 1 | Output byte present |
| out_sof | output | 1 | First byte of a frame (row 0, column 0) |
| out_row | output | 4 | Row of the output byte, 0 to 8 |
| out_col | output | 9 | Column of the output byte, 0 to 260 |

## Verification
Two events can fall in the same cycle: a stall on the lane-2 byte at column 260 of row 8, which also ends the frame, and the row and frame wrap that follows it. The same holds for a stall on the overhead byte that must carry the frame-start strobe. The bench provokes both by withdrawing valid on random cycles across whole frames, after two frames with every source always valid. A behavioural model tracks the scan position and per-lane sequence numbers and judges data, position, strobe and readies on every clock. Any byte that is dropped, duplicated or emitted out of turn therefore shows up at once.

// File: rtl/vc4_ilv_pkg.sv
// Shared types and defaults for the VC-4 interleaver.
// Assumes one overhead column at column 0, followed by stuff columns, then the lanes.
package vc4_ilv_pkg;
    typedef enum logic [1:0] {
        RG_POH   = 2'd0,
        RG_STUFF = 2'd1,
        RG_TUG   = 2'd2
    } col_region_e;

    parameter int DEF_DATA_W     = 8;
    parameter int DEF_ROWS       = 9;
    parameter int DEF_N_TUG      = 3;
    parameter int DEF_TUG_COLS   = 86;
    parameter int DEF_STUFF_COLS = 2;
endpackage

// File: rtl/vc4_pos_ctr.sv
// Row/column scan counter for the VC-4 frame.
// Advances one column per accepted byte and wraps row and frame. Holds on a stall.
module vc4_pos_ctr #(
    parameter int ROWS  = 9,
    parameter int COLS  = 261,
    parameter int ROW_W = 4,
    parameter int COL_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv,
    output logic [ROW_W-1:0] row,
    output logic [COL_W-1:0] col
);
    localparam logic [ROW_W-1:0] LAST_ROW = ROW_W'(ROWS - 1);
    localparam logic [COL_W-1:0] LAST_COL = COL_W'(COLS - 1);

    // Step the scan position on each accepted byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            row <= '0;
            col <= '0;
        end else if (adv) begin
            if (col == LAST_COL) begin
                col <= '0;
                row <= (row == LAST_ROW) ? '0 : row + 1'b1;
            end else begin
                col <= col + 1'b1;
            end
        end
    end
endmodule

// File: rtl/vc4_lane_sched.sv
// Decodes the column region and rotates the lane whose turn it is.
// Assumes the lane count divides the interleaved column count. The lane also clears at row end.
module vc4_lane_sched
    import vc4_ilv_pkg::*;
#(
    parameter int N_TUG     = 3,
    parameter int LEAD_COLS = 3,
    parameter int COLS      = 261,
    parameter int COL_W     = 9,
    parameter int LANE_W    = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              adv,
    input  logic [COL_W-1:0]  col,
    output col_region_e       region,
    output logic [LANE_W-1:0] lane,
    output logic              poh_ready,
    output logic [N_TUG-1:0]  tug_ready
);
    localparam logic [COL_W-1:0]  LEAD_C   = COL_W'(LEAD_COLS);
    localparam logic [COL_W-1:0]  LAST_COL = COL_W'(COLS - 1);
    localparam logic [LANE_W-1:0] LAST_LN  = LANE_W'(N_TUG - 1);

    // Classify the current column.
    always_comb begin
        if (col == '0)          region = RG_POH;
        else if (col < LEAD_C)  region = RG_STUFF;
        else                    region = RG_TUG;
    end

    // Rotate the lane after each interleaved byte and clear it at row end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lane <= '0;
        end else if (adv) begin
            if (col == LAST_COL)       lane <= '0;
            else if (region == RG_TUG) lane <= (lane == LAST_LN) ? '0 : lane + 1'b1;
        end
    end

    assign poh_ready = (region == RG_POH);

    genvar g;
    generate
        for (g = 0; g < N_TUG; g++) begin : g_rdy
            // Offer ready to lane g only on its own column.
            assign tug_ready[g] = (region == RG_TUG) && (lane == LANE_W'(g));
        end
    endgenerate

    // R5: at most one source is offered ready in any cycle.
    assert_one_ready_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({poh_ready, tug_ready}));

    // R3: nothing is consumed during the stuff columns.
    assert_stuff_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (region == RG_STUFF) |-> (!poh_ready && tug_ready == '0));
endmodule

// File: rtl/vc4_byte_mux.sv
// Selects the byte for the current column and reports whether it is available.
// Stuff columns are always available and carry the fixed stuff value.
module vc4_byte_mux
    import vc4_ilv_pkg::*;
#(
    parameter int          DATA_W     = 8,
    parameter int          N_TUG      = 3,
    parameter int          LANE_W     = 2,
    parameter logic [7:0]  STUFF_BYTE = 8'h00
) (
    input  col_region_e              region,
    input  logic [LANE_W-1:0]        lane,
    input  logic [DATA_W-1:0]        poh_data,
    input  logic                     poh_valid,
    input  logic [N_TUG*DATA_W-1:0]  tug_data,
    input  logic [N_TUG-1:0]         tug_valid,
    output logic [DATA_W-1:0]        sel_byte,
    output logic                     sel_ok
);
    // Route the due source to the output and flag its presence.
    always_comb begin
        case (region)
            RG_POH: begin
                sel_byte = poh_data;
                sel_ok   = poh_valid;
            end
            RG_STUFF: begin
                sel_byte = DATA_W'(STUFF_BYTE);
                sel_ok   = 1'b1;
            end
            default: begin
                sel_byte = tug_data[lane*DATA_W +: DATA_W];
                sel_ok   = tug_valid[lane];
            end
        endcase
    end
endmodule

// File: rtl/vc4_tug3_interleaver.sv
// Top: builds a VC-4 row by row from one overhead column, the stuff columns
// and three byte-interleaved TUG-3 lanes. Stalls whenever the due source is absent.
// The output is registered: one cycle from acceptance to out_valid.
module vc4_tug3_interleaver
    import vc4_ilv_pkg::*;
#(
    parameter int DATA_W     = DEF_DATA_W,
    parameter int ROWS       = DEF_ROWS,
    parameter int N_TUG      = DEF_N_TUG,
    parameter int TUG_COLS   = DEF_TUG_COLS,
    parameter int STUFF_COLS = DEF_STUFF_COLS
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [DATA_W-1:0]        poh_data,
    input  logic                     poh_valid,
    output logic                     poh_ready,
    input  logic [N_TUG*DATA_W-1:0]  tug_data,
    input  logic [N_TUG-1:0]         tug_valid,
    output logic [N_TUG-1:0]         tug_ready,
    output logic [DATA_W-1:0]        out_data,
    output logic                     out_valid,
    output logic                     out_sof,
    output logic [$clog2(ROWS)-1:0]  out_row,
    output logic [$clog2(1+STUFF_COLS+N_TUG*TUG_COLS)-1:0] out_col
);
    localparam int LEAD_COLS = 1 + STUFF_COLS;
    localparam int COLS      = LEAD_COLS + N_TUG * TUG_COLS;
    localparam int ROW_W     = $clog2(ROWS);
    localparam int COL_W     = $clog2(COLS);
    localparam int LANE_W    = (N_TUG > 1) ? $clog2(N_TUG) : 1;
    localparam logic [COL_W-1:0] STUFF_LO = COL_W'(1);
    localparam logic [COL_W-1:0] STUFF_HI = COL_W'(LEAD_COLS - 1);
    localparam logic [COL_W-1:0] LAST_COL = COL_W'(COLS - 1);

    logic [ROW_W-1:0]  cur_row;
    logic [COL_W-1:0]  cur_col;
    logic [LANE_W-1:0] cur_lane;
    col_region_e       cur_region;
    logic [DATA_W-1:0] sel_byte;
    logic              adv;

    vc4_pos_ctr #(.ROWS(ROWS), .COLS(COLS), .ROW_W(ROW_W), .COL_W(COL_W)) u_pos (
        .clk(clk), .rst_n(rst_n), .adv(adv), .row(cur_row), .col(cur_col)
    );

    vc4_lane_sched #(.N_TUG(N_TUG), .LEAD_COLS(LEAD_COLS), .COLS(COLS),
                     .COL_W(COL_W), .LANE_W(LANE_W)) u_sched (
        .clk(clk), .rst_n(rst_n), .adv(adv), .col(cur_col),
        .region(cur_region), .lane(cur_lane),
        .poh_ready(poh_ready), .tug_ready(tug_ready)
    );

    vc4_byte_mux #(.DATA_W(DATA_W), .N_TUG(N_TUG), .LANE_W(LANE_W),
                   .STUFF_BYTE(8'h00)) u_mux (
        .region(cur_region), .lane(cur_lane),
        .poh_data(poh_data), .poh_valid(poh_valid),
        .tug_data(tug_data), .tug_valid(tug_valid),
        .sel_byte(sel_byte), .sel_ok(adv)
    );

    // Register the accepted byte together with its position and frame-start strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_sof   <= 1'b0;
            out_data  <= '0;
            out_row   <= '0;
            out_col   <= '0;
        end else begin
            out_valid <= adv;
            out_sof   <= adv && (cur_row == '0) && (cur_col == '0);
            if (adv) begin
                out_data <= sel_byte;
                out_row  <= cur_row;
                out_col  <= cur_col;
            end
        end
    end

    // R6: a stall leaves the scan position where it was.
    assert_stall_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !adv |=> ($stable(cur_col) && $stable(cur_row)));

    // R7: the last column is followed by column 0.
    assert_row_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && cur_col == LAST_COL) |=> (cur_col == '0));

    // R8: the frame-start strobe marks only a valid byte at row 0, column 0.
    assert_sof_pos_R8: assert property (@(posedge clk) disable iff (!rst_n)
        out_sof |-> (out_valid && out_row == '0 && out_col == '0));

    // R3: bytes emitted on the stuff columns are zero.
    assert_stuff_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_col >= STUFF_LO && out_col <= STUFF_HI) |-> (out_data == '0));

    // R9: an output byte always follows an accepted byte.
    assert_out_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(adv));
endmodule

// File: tb/sim_vc4_tug3_interleaver.sv
// Bench: a behavioural model of the scan order is compared with the design on every clock.
module sim_vc4_tug3_interleaver;
    localparam int NROW = 9;
    localparam int NCOL = 261;
    localparam int FRAME = NROW * NCOL;
    localparam int NCYC = 5 * FRAME;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  poh_data = '0;
    logic        poh_valid = 1'b0;
    logic        poh_ready;
    logic [23:0] tug_data = '0;
    logic [2:0]  tug_valid = '0;
    logic [2:0]  tug_ready;
    logic [7:0]  out_data;
    logic        out_valid;
    logic        out_sof;
    logic [3:0]  out_row;
    logic [8:0]  out_col;

    int n_chk = 0;
    int n_fail = 0;

    vc4_tug3_interleaver u0 (
        .clk(clk), .rst_n(rst_n),
        .poh_data(poh_data), .poh_valid(poh_valid), .poh_ready(poh_ready),
        .tug_data(tug_data), .tug_valid(tug_valid), .tug_ready(tug_ready),
        .out_data(out_data), .out_valid(out_valid), .out_sof(out_sof),
        .out_row(out_row), .out_col(out_col)
    );

    always #10 clk = ~clk;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Model state
    int mrow = 0, mcol = 0;
    int poh_seq = 0;
    int lseq [3] = '{0, 0, 0};
    bit  e_valid = 0, e_sof = 0;
    int  e_data = 0, e_row = 0, e_col = 0;

    initial begin
        #(20 * (NCYC + 200));
        n_fail++;
        $display("FAIL watchdog: actual hang expected finish");
        $display("%0d/%0d checks passed", n_chk - n_fail + 1, n_chk + 1);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(out_valid == 0, "R1", "out_valid in reset", out_valid, 0);
        chk(out_sof == 0, "R1", "out_sof in reset", out_sof, 0);
        chk(poh_ready == 1, "R1", "poh_ready in reset", poh_ready, 1);
        chk(tug_ready == 0, "R1", "tug_ready in reset", tug_ready, 0);
        rst_n = 1'b1;
        for (int cyc = 0; cyc < NCYC; cyc++) begin
            bit full, take;
            int lane, exp_r;
            if (cyc > 0) @(negedge clk);
            // Outputs from the previous cycle's acceptance
            if (cyc == 0) begin
                chk(out_valid == 0, "R1", "out_valid after reset", out_valid, 0);
            end else if (e_valid) begin
                string tg;
                if (e_col == 0) tg = "R2";
                else if (e_col < 3) tg = "R3";
                else tg = "R4";
                chk(out_valid == 1, "R9", "out_valid", out_valid, 1);
                chk(out_data == 8'(e_data), tg, "out_data", out_data, e_data);
                chk(out_row == 4'(e_row) && out_col == 9'(e_col), "R7", "position",
                    {out_row, out_col}, {e_row[3:0], e_col[8:0]});
                chk(out_sof == e_sof, "R8", "out_sof", out_sof, e_sof);
            end else begin
                chk(out_valid == 0, "R6", "out_valid on stall", out_valid, 0);
                chk(out_sof == 0, "R8", "out_sof on stall", out_sof, 0);
            end
            // Drive new inputs: two full-rate frames, then random gaps
            full = (cyc < 2 * FRAME);
            poh_valid = full || ($urandom % 4 != 0);
            poh_data  = 8'(poh_seq);
            for (int l = 0; l < 3; l++) begin
                tug_valid[l] = full || ($urandom % 3 != 0);
                tug_data[l*8 +: 8] = {2'(l), 6'(lseq[l])};
            end
            #1;
            exp_r = (mcol == 0) ? 1 : 0;
            chk(poh_ready == 1'(exp_r), "R2", "poh_ready", poh_ready, exp_r);
            lane = (mcol >= 3) ? (mcol - 3) % 3 : -1;
            for (int l = 0; l < 3; l++) begin
                exp_r = (lane == l) ? 1 : 0;
                chk(tug_ready[l] == 1'(exp_r), "R5", "tug_ready", tug_ready[l], exp_r);
            end
            // Model the acceptance
            if (mcol == 0)      take = poh_valid;
            else if (mcol < 3)  take = 1;
            else                take = tug_valid[lane];
            e_valid = take;
            if (take) begin
                e_row = mrow;
                e_col = mcol;
                e_sof = (mrow == 0 && mcol == 0);
                if (mcol == 0) begin
                    e_data = poh_seq % 256;
                    poh_seq++;
                end else if (mcol < 3) begin
                    e_data = 0;
                end else begin
                    e_data = (lane << 6) | (lseq[lane] % 64);
                    lseq[lane]++;
                end
                if (mcol == NCOL - 1) begin
                    mcol = 0;
                    mrow = (mrow == NROW - 1) ? 0 : mrow + 1;
                end else begin
                    mcol++;
                end
            end
        end
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule